// File: doc/BRIEF.md
# Serial RTU Frame CRC Checker

This block sits behind a byte-level serial receiver and turns its stream of received characters into frames. A frame opens with the first byte that arrives while the line is idle. It closes once the line has been silent for a set number of bit times. No delimiter characters are used. A bit-time tick from the receiver clocks the silence timer, so the gap threshold is set in bit times and does not depend on the system clock.

While a frame is open, every byte is folded into a reflected 16-bit CRC. The CRC is seeded with all ones and uses the shift-right constant 0xA001. When the gap closes the frame, the block compares the CRC of the leading bytes with the two trailing check bytes, which carry the low byte first. It then gives one verdict: good, CRC error, or length error. The first byte of the frame (the station address) and the number of bytes received stay on the outputs for the downstream decoder.

A parameter chooses how the CRC is compared. One variant keeps a two-byte history and compares the received check word directly. The other runs the CRC through the check bytes as well and tests for a zero residue. Both variants give the same verdict.

Top module: `rtu_frame_checker`

## Requirements
- R1: While reset is held and in the first cycle after it, frame_start, frame_end, frame_ok, crc_err and len_err are 0, and byte_count is 0.
- R2: A byte accepted while no frame is open opens a frame. One cycle after the byte's clock edge, frame_start pulses for one cycle, addr_out equals that byte, and byte_count equals 1.
- R3: byte_count rises by one for each accepted byte of an open frame, saturates at MAX_LEN+1, and keeps its value after the frame closes until the next frame opens.
- R4: A frame closes when GAP_TICKS bit_tick pulses (default 39, which is 3.5 characters of 11 bits) have been seen with no byte since the last one. An accepted byte restarts the count. Cycles with bit_tick low do not count. Ticks while no frame is open have no effect. frame_end pulses in the cycle after the closing tick's edge.
- R5: The CRC starts at 0xFFFF for each frame. For each byte, the byte is XORed into the low 8 bits, and then 8 times the register shifts right with 0 entering bit 15 and is XORed with 0xA001 whenever the bit shifted out was 1. frame_ok pulses with frame_end when the last byte equals bits 15:8 and the second-to-last byte equals bits 7:0 of the CRC of all earlier bytes.
- R6: crc_err pulses with frame_end when the length is valid but the trailing two bytes do not match the computed CRC.
- R7: A frame with fewer than MIN_LEN (4) or more than MAX_LEN (256) bytes raises len_err with frame_end, and neither frame_ok nor crc_err is raised.
- R8: Exactly one of frame_ok, crc_err and len_err is 1 in each frame_end cycle, and all three are 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received character |
| rx_byte | input | 8 | Data bits of the received character |
| bit_tick | input | 1 | One pulse per serial bit time, clocks the idle timer |
| frame_start | output | 1 | Pulse: a new frame has opened |
| frame_end | output | 1 | Pulse: the idle gap has closed the frame |
| frame_ok | output | 1 | Pulse with frame_end: length valid and CRC matches |
| crc_err | output | 1 | Pulse with frame_end: length valid, CRC mismatch |
| len_err | output | 1 | Pulse with frame_end: too few or too many bytes |
| addr_out | output | 8 | First byte of the current or last frame |
| byte_count | output | CNT_W (9) | Bytes received in the current or last frame |

## Verification
frame_start, addr_out and the count of one are due one cycle after the edge that captures the opening byte. Each later byte raises the count at its own capture edge. frame_end and its verdict flag are due at the edge of the GAP_TICKS-th tick after the last byte. With a tick in every cycle, that is 39 edges after the last byte is captured. The bench drives inputs on falling edges and reads outputs on falling edges. It confirms that frame_end is still low one falling edge before the due edge and high right after it. A monitor pops the expected verdict, length and address from a queue at each frame_start and frame_end it sees, and reports any close that was not expected.

// File: rtl/rtu_pkg.sv
package rtu_pkg;

   localparam int RTU_BYTE_W = 8;
   localparam int RTU_CRC_W  = 2 * RTU_BYTE_W;

   typedef logic [RTU_BYTE_W-1:0] rtu_byte_t;
   typedef logic [RTU_CRC_W-1:0]  rtu_crc_t;

   typedef enum logic [1:0] {
      RTU_ST_OK      = 2'd0,
      RTU_ST_CRC_BAD = 2'd1,
      RTU_ST_LEN_BAD = 2'd2
   } rtu_status_e;

endpackage

// File: rtl/rtu_crc_byte.sv
module rtu_crc_byte
   import rtu_pkg::*;
#(
   parameter rtu_crc_t POLY = 16'hA001
) (
   input  rtu_crc_t  crc_in,
   input  rtu_byte_t data_in,
   output rtu_crc_t  crc_out
);

   always_comb begin
      rtu_crc_t acc;
      acc = crc_in ^ {{(RTU_CRC_W-RTU_BYTE_W){1'b0}}, data_in};
      for (int i = 0; i < RTU_BYTE_W; i++) begin
         if (acc[0]) acc = (acc >> 1) ^ POLY;
         else        acc = acc >> 1;
      end
      crc_out = acc;
   end

endmodule

// File: rtl/rtu_idle_timer.sv
module rtu_idle_timer #(
   parameter int GAP_TICKS = 39,
   localparam int TW = $clog2(GAP_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic restart,
   input  logic tick,
   output logic expire
);

   logic [TW-1:0] quiet_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                quiet_q <= '0;
      else if (restart || !active) quiet_q <= '0;
      else if (tick)             quiet_q <= quiet_q + 1'b1;
   end

   assign expire = active && !restart && tick && (quiet_q == TW'(GAP_TICKS - 1));

endmodule

// File: rtl/rtu_frame_checker.sv
module rtu_frame_checker
   import rtu_pkg::*;
#(
   parameter int       CHAR_BITS      = 11,
   parameter int       GAP_HALF_CHARS = 7,
   parameter int       MAX_LEN        = 256,
   parameter int       MIN_LEN        = 4,
   parameter bit       CHECK_RESIDUE  = 1'b0,
   parameter rtu_crc_t CRC_POLY       = 16'hA001,
   parameter rtu_crc_t CRC_SEED       = 16'hFFFF,
   localparam int GAP_TICKS = (CHAR_BITS * GAP_HALF_CHARS + 1) / 2,
   localparam int CNT_W     = $clog2(MAX_LEN + 2)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_valid,
   input  logic [7:0]      rx_byte,
   input  logic            bit_tick,
   output logic            frame_start,
   output logic            frame_end,
   output logic            frame_ok,
   output logic            crc_err,
   output logic            len_err,
   output logic [7:0]      addr_out,
   output logic [CNT_W-1:0] byte_count
);

   // elaboration-time parameter checks
   if (MIN_LEN < 3) begin : g_min_len_bad
      $error("MIN_LEN must leave room for an address byte and two check bytes");
   end
   if (MAX_LEN < MIN_LEN) begin : g_max_len_bad
      $error("MAX_LEN must not be below MIN_LEN");
   end
   if (GAP_TICKS < 1) begin : g_gap_bad
      $error("idle gap must be at least one bit time");
   end

   logic        in_frame_q;
   logic        gap_done;
   logic        crc_good;
   rtu_crc_t    crc_q, crc_in, crc_nx;
   rtu_status_e verdict;
   logic        len_bad;
   logic [CNT_W-1:0] cnt_q;
   rtu_byte_t   addr_q;
   logic        start_q, end_q, ok_q, crcbad_q, lenbad_q;

   assign crc_in = in_frame_q ? crc_q : CRC_SEED;

   rtu_crc_byte #(.POLY(CRC_POLY)) u_crc (
      .crc_in (crc_in),
      .data_in(rx_byte),
      .crc_out(crc_nx)
   );

   rtu_idle_timer #(.GAP_TICKS(GAP_TICKS)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (in_frame_q),
      .restart(rx_valid),
      .tick   (bit_tick),
      .expire (gap_done)
   );

   generate
      if (CHECK_RESIDUE) begin : g_residue
         assign crc_good = (crc_q == '0);
      end else begin : g_compare
         rtu_crc_t  hist1_q, hist2_q;
         rtu_byte_t last_q, prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hist1_q <= '0;
               hist2_q <= '0;
               last_q  <= '0;
               prev_q  <= '0;
            end else if (rx_valid) begin
               hist2_q <= hist1_q;
               hist1_q <= crc_in;
               prev_q  <= last_q;
               last_q  <= rx_byte;
            end
         end
         assign crc_good = (hist2_q == {last_q, prev_q});
      end
   endgenerate

   always_comb begin
      len_bad = (cnt_q < CNT_W'(MIN_LEN)) || (cnt_q > CNT_W'(MAX_LEN));
      if (len_bad)       verdict = RTU_ST_LEN_BAD;
      else if (crc_good) verdict = RTU_ST_OK;
      else               verdict = RTU_ST_CRC_BAD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         crc_q      <= CRC_SEED;
         cnt_q      <= '0;
         addr_q     <= '0;
         start_q    <= 1'b0;
         end_q      <= 1'b0;
         ok_q       <= 1'b0;
         crcbad_q   <= 1'b0;
         lenbad_q   <= 1'b0;
      end else begin
         start_q  <= 1'b0;
         end_q    <= 1'b0;
         ok_q     <= 1'b0;
         crcbad_q <= 1'b0;
         lenbad_q <= 1'b0;
         if (rx_valid) begin
            crc_q <= crc_nx;
            if (!in_frame_q) begin
               in_frame_q <= 1'b1;
               start_q    <= 1'b1;
               cnt_q      <= CNT_W'(1);
               addr_q     <= rx_byte;
            end else if (cnt_q <= CNT_W'(MAX_LEN)) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (gap_done) begin
            in_frame_q <= 1'b0;
            end_q      <= 1'b1;
            ok_q       <= (verdict == RTU_ST_OK);
            crcbad_q   <= (verdict == RTU_ST_CRC_BAD);
            lenbad_q   <= (verdict == RTU_ST_LEN_BAD);
         end
      end
   end

   assign frame_start = start_q;
   assign frame_end   = end_q;
   assign frame_ok    = ok_q;
   assign crc_err     = crcbad_q;
   assign len_err     = lenbad_q;
   assign addr_out    = addr_q;
   assign byte_count  = cnt_q;

endmodule

// File: rtl/rtu_frame_checker_chk.sv
module rtu_frame_checker_chk #(
   parameter int CNT_W   = 9,
   parameter int MAX_LEN = 256,
   parameter int MIN_LEN = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic [7:0]       rx_byte,
   input logic             frame_start,
   input logic             frame_end,
   input logic             frame_ok,
   input logic             crc_err,
   input logic             len_err,
   input logic [7:0]       addr_out,
   input logic [CNT_W-1:0] byte_count
);

   // R8
   verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> $countones({frame_ok, crc_err, len_err}) == 1);

   // R8
   verdict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |-> !(frame_ok || crc_err || len_err));

   // R2
   open_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (byte_count == CNT_W'(1)) && (addr_out == $past(rx_byte)));

   // R2
   start_end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_start && frame_end));

   // R4
   close_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> !$past(rx_valid));

   // R3
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rx_valid) |-> $stable(byte_count));

   // R3
   count_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_count <= CNT_W'(MAX_LEN + 1));

   // R7
   len_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ok || crc_err) |-> (byte_count >= CNT_W'(MIN_LEN)) && (byte_count <= CNT_W'(MAX_LEN)));

   // R7
   len_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |-> (byte_count < CNT_W'(MIN_LEN)) || (byte_count > CNT_W'(MAX_LEN)));

endmodule

bind rtu_frame_checker rtu_frame_checker_chk #(
   .CNT_W  (CNT_W),
   .MAX_LEN(MAX_LEN),
   .MIN_LEN(MIN_LEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .rx_byte    (rx_byte),
   .frame_start(frame_start),
   .frame_end  (frame_end),
   .frame_ok   (frame_ok),
   .crc_err    (crc_err),
   .len_err    (len_err),
   .addr_out   (addr_out),
   .byte_count (byte_count)
);

// File: tb/rtu_frame_checker_test.sv
module rtu_frame_checker_test;

   localparam int GAP   = 39;
   localparam int MAXL  = 256;
   localparam int MINL  = 4;
   localparam int CW    = $clog2(MAXL + 2);
   localparam int ST_OK = 0, ST_CRC = 1, ST_LEN = 2;

   typedef struct {
      logic [7:0] addr;
      int         count;
      int         status;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0;
   logic [7:0]    rx_byte = '0;
   logic          bit_tick = 1'b1;
   logic          frame_start, frame_end, frame_ok, crc_err, len_err;
   logic [7:0]    addr_out;
   logic [CW-1:0] byte_count;

   int   n_checks = 0;
   int   n_fail   = 0;
   int   ends_seen = 0;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   rtu_frame_checker #(
      .CHAR_BITS(11), .GAP_HALF_CHARS(7), .MAX_LEN(MAXL), .MIN_LEN(MINL)
   ) uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .bit_tick(bit_tick), .frame_start(frame_start), .frame_end(frame_end),
      .frame_ok(frame_ok), .crc_err(crc_err), .len_err(len_err),
      .addr_out(addr_out), .byte_count(byte_count)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc16(input logic [7:0] d[$]);
      logic [15:0] c;
      c = 16'hFFFF;
      foreach (d[i]) begin
         c = c ^ {8'h00, d[i]};
         for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
      end
      return c;
   endfunction

   function automatic void seal(ref logic [7:0] d[$]);
      logic [15:0] c;
      c = crc16(d);
      d.push_back(c[7:0]);
      d.push_back(c[15:8]);
   endfunction

   task automatic drive_byte(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   // after the last byte: frame_end low at edge GAP-1, high right after edge GAP
   task automatic close_frame(input int exp_count);
      repeat (GAP - 1) @(negedge clk);
      chk(frame_end == 1'b0, "R4 early close", int'(frame_end), 0);
      @(negedge clk);
      chk(frame_end == 1'b1, "R4 close timing", int'(frame_end), 1);
      repeat (3) @(negedge clk);
      chk(int'(byte_count) == exp_count, "R3 count held after close", int'(byte_count), exp_count);
   endtask

   task automatic send_frame(input logic [7:0] d[$], input int status);
      exp_t e;
      e.addr = d[0];
      e.count = (d.size() > MAXL) ? MAXL + 1 : d.size();
      e.status = status;
      exp_q.push_back(e);
      foreach (d[i]) drive_byte(d[i]);
      close_frame(e.count);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && frame_start) begin
            chk(exp_q.size() > 0, "R2 unexpected start", 1, 0);
            if (exp_q.size() > 0) begin
               chk(addr_out == exp_q[0].addr, "R2 address", int'(addr_out), int'(exp_q[0].addr));
               chk(int'(byte_count) == 1, "R2 first count", int'(byte_count), 1);
            end
         end
         if (rst_n && frame_end) begin
            exp_t e;
            ends_seen++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected close", 1, 0);
            end else begin
               int st;
               e = exp_q.pop_front();
               st = frame_ok ? ST_OK : (crc_err ? ST_CRC : (len_err ? ST_LEN : -1));
               chk(st == e.status, (e.status == ST_OK) ? "R5 verdict" :
                   (e.status == ST_CRC) ? "R6 verdict" : "R7 verdict", st, e.status);
               chk($countones({frame_ok, crc_err, len_err}) == 1, "R8 single flag",
                   $countones({frame_ok, crc_err, len_err}), 1);
               chk(int'(byte_count) == e.count, "R3 final count", int'(byte_count), e.count);
            end
         end else if (rst_n) begin
            if (frame_ok || crc_err || len_err)
               chk(1'b0, "R8 flag outside close", 1, 0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] f[$];
      int base;

      // R1 reset state
      repeat (3) @(negedge clk);
      chk({frame_start, frame_end, frame_ok, crc_err, len_err} == 5'b0, "R1 pulses in reset",
          int'({frame_start, frame_end, frame_ok, crc_err, len_err}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({frame_start, frame_end, frame_ok, crc_err, len_err} == 5'b0, "R1 pulses after reset",
          int'({frame_start, frame_end, frame_ok, crc_err, len_err}), 0);
      chk(int'(byte_count) == 0, "R1 count", int'(byte_count), 0);

      // R4 ticks with no frame open
      repeat (100) @(negedge clk);
      chk(ends_seen == 0, "R4 idle ticks ignored", ends_seen, 0);

      // R5 read request, good CRC
      f = '{8'h01, 8'h03, 8'h00, 8'h01, 8'h00, 8'h02};
      seal(f);
      send_frame(f, ST_OK);

      // R6 corrupted check byte
      f = '{8'h11, 8'h06, 8'h00, 8'h10, 8'hAB, 8'hCD};
      seal(f);
      f[f.size()-1] = f[f.size()-1] ^ 8'h40;
      send_frame(f, ST_CRC);

      // R6 swapped check bytes (high first) must fail
      f = '{8'h22, 8'h03, 8'h12, 8'h34};
      seal(f);
      begin
         logic [7:0] t;
         t = f[4]; f[4] = f[5]; f[5] = t;
      end
      send_frame(f, (f[4] == f[5]) ? ST_OK : ST_CRC);

      // R7 minimum length, good
      f = '{8'h05, 8'h07};
      seal(f);
      send_frame(f, ST_OK);

      // R7 three bytes too short
      f = '{8'h09, 8'h01, 8'h02};
      send_frame(f, ST_LEN);

      // R7 single byte
      f = '{8'h3C};
      send_frame(f, ST_LEN);

      // R7 maximum length, good
      f = {};
      for (int i = 0; i < MAXL - 2; i++) f.push_back(8'(i * 7 + 3));
      seal(f);
      send_frame(f, ST_OK);

      // R7 overlong, count saturates (R3)
      f = {};
      for (int i = 0; i < MAXL + 4; i++) f.push_back(8'(i ^ 8'h5A));
      send_frame(f, ST_LEN);

      // R4 pauses shorter than the gap, and tick held low, keep one frame
      f = '{8'h47, 8'h10, 8'h00, 8'h20, 8'h00, 8'h02};
      seal(f);
      begin
         exp_t e;
         e.addr = f[0]; e.count = f.size(); e.status = ST_OK;
         exp_q.push_back(e);
      end
      base = ends_seen;
      foreach (f[i]) begin
         drive_byte(f[i]);
         if (i == 1) begin
            bit_tick = 1'b0;
            repeat (100) @(negedge clk);
            bit_tick = 1'b1;
         end
         if (i == 3) repeat (GAP - 3) @(negedge clk);
      end
      chk(ends_seen == base, "R4 pauses keep frame open", ends_seen, base);
      close_frame(f.size());

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R4 all frames closed", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule